// File: doc/BRIEF.md
# Sector-Mapped Read Cache

This block is a read-only cache whose storage is split into a small number of large sectors. Each sector holds a run of consecutive memory blocks under a single address tag. A memory sector may sit in any cache sector, so every tag is compared in parallel on each lookup. Validity is tracked per block, not per sector. A miss fetches only the block that was asked for. A miss on the tag itself first takes over a whole sector and discards every block it held.

The CPU side presents a word address under a valid/ready handshake. A hit returns the word on the next cycle with a one-cycle hit strobe. A miss raises a block-fill request to memory with the block address. Memory then streams the block's words in order under a valid/ready handshake, and the cache returns the requested word once the block is complete. The default configuration has 8 sectors of 16 blocks of 16 words. This gives an 18-bit word address: a 10-bit tag, a 4-bit block index and a 4-bit word offset.

Top module: `sector_cache`

## Requirements
- R1: A synchronous active-high reset clears every tag-valid flag, every block-valid bit and the round-robin pointer. Afterwards `req_ready`=1, `fill_req`=0 and `rsp_hit`=0, and the first lookup of any address misses.
- R2: The word address splits as tag = `req_addr[17:8]`, block index = `req_addr[7:4]` and word offset = `req_addr[3:0]`. During a fill, `fill_blk_addr` equals `req_addr[17:4]` of the missing request.
- R3: A request is accepted when `req_valid` and `req_ready` are both 1. The lookup hits when a tag-valid sector's tag matches and that sector's addressed block is valid. On a hit, `rsp_hit` is 1 in the following cycle, with the addressed word on `rsp_data`.
- R4: A request whose tag matches a valid sector but whose block is invalid fills only that block into that sector. Every block already valid there stays valid and keeps hitting.
- R5: A fill holds `fill_req` at 1 with a constant `fill_blk_addr` and moves exactly 16 words, word 0 first. A word is taken in each cycle where `fill_valid` and `fill_ready` are both 1. `fill_req` drops after the last word.
- R6: One cycle after `fill_req` drops, `rsp_hit` is 1 and `rsp_data` carries the requested word from the new block.
- R7: A fill sets the valid bit of only the requested block. The other blocks of that sector stay invalid and miss when they are referenced.
- R8: On a tag miss, the victim is the lowest-numbered sector with a clear tag-valid flag. If no such sector exists, the victim is the sector named by the round-robin pointer. Every sector allocation advances the pointer by one, modulo the sector count. The victim takes the new tag, and all its block-valid bits are cleared.
- R9: `req_ready` is 0 from the cycle after a miss is accepted until the response cycle, so no request is taken during a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | CPU read request present |
| req_addr | input | 18 | CPU word address |
| req_ready | output | 1 | Cache can take a request this cycle |
| rsp_hit | output | 1 | One-cycle strobe: `rsp_data` holds the requested word |
| rsp_data | output | 32 | Returned word |
| fill_req | output | 1 | Block fill in progress |
| fill_blk_addr | output | 14 | Memory block address being filled (tag and block index) |
| fill_valid | input | 1 | Memory presents a fill word |
| fill_data | input | 32 | Fill word |
| fill_ready | output | 1 | Cache takes a fill word this cycle |

## Verification
The assertions assume that memory supplies fill words only while `fill_req` is high, and that it never sends more than the block length. They also assume that the CPU raises `req_valid` only when it is prepared to wait for `req_ready`. The bench stays inside these limits. It presents each request for exactly one accepting cycle and returns fill words only after seeing `fill_req`, sometimes with a stall cycle in the middle. It sends exactly 16 words per fill, and it issues no new request until the previous response has appeared.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_RESP = 2'd2
   } sc_state_e;
endpackage

// File: rtl/sc_tag_dir.sv
module sc_tag_dir #(
   parameter int NUM_SECT = 8,
   parameter int BLKS     = 16,
   parameter int TAG_W    = 10,
   localparam int SIDX_W  = $clog2(NUM_SECT),
   localparam int BIDX_W  = $clog2(BLKS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [BIDX_W-1:0] lk_blk,
   output logic              lk_sect_hit,
   output logic [SIDX_W-1:0] lk_sect_idx,
   output logic              lk_blk_valid,
   output logic [SIDX_W-1:0] victim_idx,
   input  logic              alloc_en,
   input  logic              set_en,
   input  logic [SIDX_W-1:0] set_sect,
   input  logic [BIDX_W-1:0] set_blk
);
   logic [TAG_W-1:0]  tag_q  [NUM_SECT];
   logic [BLKS-1:0]   bval_q [NUM_SECT];
   logic [NUM_SECT-1:0] tval_q;
   logic [NUM_SECT-1:0] match;
   logic [SIDX_W-1:0] rr_q;

   // parallel comparators, one per sector
   for (genvar g = 0; g < NUM_SECT; g++) begin : g_cmp
      assign match[g] = tval_q[g] && (tag_q[g] == lk_tag);
   end

   always_comb begin
      lk_sect_idx = '0;
      for (int i = 0; i < NUM_SECT; i++)
         if (match[i]) lk_sect_idx = SIDX_W'(i);
   end

   assign lk_sect_hit  = |match;
   assign lk_blk_valid = lk_sect_hit && bval_q[lk_sect_idx][lk_blk];

   // lowest free sector, else round-robin choice
   always_comb begin
      victim_idx = rr_q;
      for (int i = NUM_SECT - 1; i >= 0; i--)
         if (!tval_q[i]) victim_idx = SIDX_W'(i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tval_q <= '0;
         rr_q   <= '0;
         for (int i = 0; i < NUM_SECT; i++) bval_q[i] <= '0;
      end else begin
         if (alloc_en) begin
            tag_q[victim_idx]  <= lk_tag;
            tval_q[victim_idx] <= 1'b1;
            bval_q[victim_idx] <= '0;
            rr_q               <= rr_q + 1'b1;
         end
         if (set_en) bval_q[set_sect][set_blk] <= 1'b1;
      end
   end
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
   parameter int AW     = 11,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk)
      if (wr_en) mem[wr_addr] <= wr_data;

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sc_fill_ctrl.sv
module sc_fill_ctrl
   import sc_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int TAG_W  = 10,
   parameter int BIDX_W = 4,
   parameter int WOFF_W = 4,
   parameter int SIDX_W = 3,
   parameter int DATA_W = 32,
   localparam int AW    = SIDX_W + BIDX_W + WOFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   input  logic              lk_sect_hit,
   input  logic [SIDX_W-1:0] lk_sect_idx,
   input  logic              lk_blk_valid,
   input  logic [SIDX_W-1:0] victim_idx,
   output logic              alloc_en,
   output logic              set_en,
   output logic [SIDX_W-1:0] set_sect,
   output logic [BIDX_W-1:0] set_blk,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [AW-1:0]     rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              fill_req,
   output logic [TAG_W+BIDX_W-1:0] fill_blk_addr,
   input  logic              fill_valid,
   output logic              fill_ready,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data
);
   sc_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SIDX_W-1:0] sect_q;
   logic [WOFF_W-1:0] wcnt_q;
   logic              accept, beat, last_beat;

   wire [BIDX_W-1:0] blk_q  = addr_q[WOFF_W +: BIDX_W];
   wire [WOFF_W-1:0] word_q = addr_q[WOFF_W-1:0];

   assign req_ready     = (state_q == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign alloc_en      = accept && !lk_sect_hit;
   assign fill_req      = (state_q == ST_FILL);
   assign fill_ready    = fill_req;
   assign fill_blk_addr = addr_q[ADDR_W-1:WOFF_W];
   assign beat          = fill_req && fill_valid;
   assign last_beat     = beat && (wcnt_q == {WOFF_W{1'b1}});
   assign wr_en         = beat;
   assign wr_addr       = {sect_q, blk_q, wcnt_q};
   assign set_en        = last_beat;
   assign set_sect      = sect_q;
   assign set_blk       = blk_q;
   assign rd_addr       = (state_q == ST_IDLE)
                          ? {lk_sect_idx, req_addr[WOFF_W +: BIDX_W], req_addr[WOFF_W-1:0]}
                          : {sect_q, blk_q, word_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         rsp_hit <= 1'b0;
         wcnt_q  <= '0;
      end else begin
         rsp_hit <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               if (lk_blk_valid) begin
                  rsp_hit  <= 1'b1;
                  rsp_data <= rd_data;
               end else begin
                  state_q <= ST_FILL;
                  addr_q  <= req_addr;
                  wcnt_q  <= '0;
                  sect_q  <= lk_sect_hit ? lk_sect_idx : victim_idx;
               end
            end
            ST_FILL: if (beat) begin
               wcnt_q <= wcnt_q + 1'b1;
               if (last_beat) state_q <= ST_RESP;
            end
            ST_RESP: begin
               rsp_hit  <= 1'b1;
               rsp_data <= rd_data;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sector_cache.sv
module sector_cache #(
   parameter int NUM_SECT      = 8,
   parameter int BLKS_PER_SECT = 16,
   parameter int WORDS_PER_BLK = 16,
   parameter int TAG_W         = 10,
   parameter int DATA_W        = 32,
   localparam int SIDX_W = $clog2(NUM_SECT),
   localparam int BIDX_W = $clog2(BLKS_PER_SECT),
   localparam int WOFF_W = $clog2(WORDS_PER_BLK),
   localparam int ADDR_W = TAG_W + BIDX_W + WOFF_W,
   localparam int FBA_W  = TAG_W + BIDX_W,
   localparam int AW     = SIDX_W + BIDX_W + WOFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              fill_req,
   output logic [FBA_W-1:0]  fill_blk_addr,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   output logic              fill_ready
);
   if (NUM_SECT < 2 || (NUM_SECT & (NUM_SECT - 1)) != 0) begin : g_bad_sect
      $error("NUM_SECT must be a power of two of at least 2");
   end
   if (BLKS_PER_SECT < 2 || (BLKS_PER_SECT & (BLKS_PER_SECT - 1)) != 0) begin : g_bad_blks
      $error("BLKS_PER_SECT must be a power of two of at least 2");
   end
   if (WORDS_PER_BLK < 2 || (WORDS_PER_BLK & (WORDS_PER_BLK - 1)) != 0) begin : g_bad_words
      $error("WORDS_PER_BLK must be a power of two of at least 2");
   end

   logic              lk_sect_hit, lk_blk_valid, alloc_en, set_en, wr_en;
   logic [SIDX_W-1:0] lk_sect_idx, victim_idx, set_sect;
   logic [BIDX_W-1:0] set_blk;
   logic [AW-1:0]     wr_addr, rd_addr;
   logic [DATA_W-1:0] rd_data;

   sc_tag_dir #(.NUM_SECT(NUM_SECT), .BLKS(BLKS_PER_SECT), .TAG_W(TAG_W)) u_dir (
      .clk, .rst,
      .lk_tag (req_addr[ADDR_W-1 -: TAG_W]),
      .lk_blk (req_addr[WOFF_W +: BIDX_W]),
      .lk_sect_hit, .lk_sect_idx, .lk_blk_valid, .victim_idx,
      .alloc_en, .set_en, .set_sect, .set_blk
   );

   sc_data_store #(.AW(AW), .DATA_W(DATA_W)) u_mem (
      .clk, .wr_en, .wr_addr, .wr_data(fill_data), .rd_addr, .rd_data
   );

   sc_fill_ctrl #(
      .ADDR_W(ADDR_W), .TAG_W(TAG_W), .BIDX_W(BIDX_W),
      .WOFF_W(WOFF_W), .SIDX_W(SIDX_W), .DATA_W(DATA_W)
   ) u_ctl (
      .clk, .rst, .req_valid, .req_addr, .req_ready,
      .lk_sect_hit, .lk_sect_idx, .lk_blk_valid, .victim_idx,
      .alloc_en, .set_en, .set_sect, .set_blk,
      .wr_en, .wr_addr, .rd_addr, .rd_data,
      .fill_req, .fill_blk_addr, .fill_valid, .fill_ready,
      .rsp_hit, .rsp_data
   );
endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
   parameter int WORDS = 16,
   parameter int FBA_W = 14,
   localparam int CNT_W = $clog2(WORDS + 1) + 1
) (
   input logic             clk,
   input logic             rst,
   input logic             req_ready,
   input logic             rsp_hit,
   input logic             fill_req,
   input logic [FBA_W-1:0] fill_blk_addr,
   input logic             fill_valid,
   input logic             fill_ready
);
   logic [CNT_W-1:0] beats_q;

   always_ff @(posedge clk) begin
      if (rst || !fill_req) beats_q <= '0;
      else if (fill_valid && fill_ready) beats_q <= beats_q + 1'b1;
   end

   // R9: no request is taken while a block is being fetched
   assert_holdoff_R9: assert property (@(posedge clk) disable iff (rst)
      fill_req |-> !req_ready);

   // R5: block address constant for the whole fill
   assert_fill_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
      (fill_req && $past(fill_req)) |-> $stable(fill_blk_addr));

   // R5: a fill ends only after exactly one block of words
   assert_fill_len_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(fill_req) |-> (beats_q == CNT_W'(WORDS)));

   // R6: the response follows the end of a fill
   assert_fill_resp_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(fill_req) |=> rsp_hit);

   // R1: nothing is returned straight out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rsp_hit && !fill_req && req_ready));
endmodule

bind sector_cache sc_checker #(.WORDS(WORDS_PER_BLK), .FBA_W(FBA_W)) u_chk (
   .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_hit(rsp_hit),
   .fill_req(fill_req), .fill_blk_addr(fill_blk_addr),
   .fill_valid(fill_valid), .fill_ready(fill_ready)
);

// File: tb/sim_sector_cache.sv
`timescale 1ns/1ps
module sim_sector_cache;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [17:0] req_addr = '0;
   logic        req_ready, rsp_hit, fill_req, fill_ready;
   logic [31:0] rsp_data;
   logic [13:0] fill_blk_addr;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_data = '0;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   sector_cache u0 (
      .clk, .rst, .req_valid, .req_addr, .req_ready, .rsp_hit, .rsp_data,
      .fill_req, .fill_blk_addr, .fill_valid, .fill_data, .fill_ready
   );

   // reference model of directory state
   logic [9:0]  m_tag [8];
   logic        m_tv  [8];
   logic [15:0] m_bv  [8];
   int          m_rr;

   function automatic logic [31:0] pat(input logic [13:0] ba, input logic [3:0] w);
      return {8'hC3, ba, 6'd0, w};
   endfunction

   function automatic logic [9:0] tg(input int i);
      return 10'((i * 37 + 5) % 1024);
   endfunction

   task automatic chk(input bit ok, input string lbl, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", lbl, act, exp);
      end
   endtask

   task automatic access(input logic [17:0] a, input string lbl, input bit stall);
      logic [9:0] t;
      logic [3:0] b, w;
      int s, n;
      bit found, exp_hit, got_hit;
      t = a[17:8]; b = a[7:4]; w = a[3:0];
      found = 0; s = 0;
      for (int i = 0; i < 8; i++)
         if (m_tv[i] && m_tag[i] == t) begin found = 1; s = i; end
      exp_hit = found && m_bv[s][b];
      n = 0;
      while (!req_ready && n < 50) begin @(negedge clk); n++; end
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      got_hit = rsp_hit;
      chk(got_hit == exp_hit, {lbl, " hit/miss"}, 64'(got_hit), 64'(exp_hit));
      if (got_hit) begin
         chk(rsp_data == pat(a[17:4], w), "R3 hit data", rsp_data, pat(a[17:4], w));
      end else begin
         chk(fill_req == 1'b1, "R5 fill_req", 64'(fill_req), 1);
         chk(fill_blk_addr == a[17:4], "R2 fill_blk_addr", fill_blk_addr, a[17:4]);
         chk(req_ready == 1'b0, "R9 req_ready in fill", 64'(req_ready), 0);
         if (!found) begin
            s = m_rr;
            for (int i = 7; i >= 0; i--) if (!m_tv[i]) s = i;
            m_tag[s] = t; m_tv[s] = 1'b1; m_bv[s] = '0;
            m_rr = (m_rr + 1) % 8;
         end
         for (int k = 0; k < 16; k++) begin
            if (stall && k == 7) begin
               fill_valid = 1'b0;
               @(negedge clk);
               chk(fill_req == 1'b1, "R5 fill_req held in stall", 64'(fill_req), 1);
            end
            fill_valid = 1'b1;
            fill_data  = pat(a[17:4], 4'(k));
            @(negedge clk);
         end
         fill_valid = 1'b0;
         chk(fill_req == 1'b0, "R5 fill_req drops after 16 words", 64'(fill_req), 0);
         m_bv[s][b] = 1'b1;
         n = 0;
         while (!rsp_hit && n < 8) begin @(negedge clk); n++; end
         chk(rsp_hit == 1'b1, "R6 response after fill", 64'(rsp_hit), 1);
         chk(rsp_data == pat(a[17:4], w), "R6 fill data", rsp_data, pat(a[17:4], w));
      end
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 150000) begin @(posedge clk); cyc++; end
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lcg;
      for (int i = 0; i < 8; i++) begin m_tv[i] = 0; m_bv[i] = '0; m_tag[i] = '0; end
      m_rr = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 1);
      chk(fill_req == 1'b0,  "R1 fill_req after reset",  64'(fill_req), 0);
      chk(rsp_hit == 1'b0,   "R1 rsp_hit after reset",   64'(rsp_hit), 0);

      access({tg(0), 4'd0, 4'd3}, "R1", 1'b0);
      for (int w = 0; w < 16; w++) access({tg(0), 4'd0, 4'(w)}, "R3", 1'b0);

      access({tg(0), 4'd1, 4'd9}, "R4", 1'b1);
      access({tg(0), 4'd0, 4'd5}, "R4", 1'b0);
      access({tg(0), 4'd2, 4'd0}, "R7", 1'b0);
      access({tg(0), 4'd1, 4'd0}, "R7", 1'b0);
      access({tg(0), 4'd3, 4'd1}, "R7", 1'b0);

      for (int i = 1; i < 8; i++) access({tg(i), 4'(i), 4'(i)}, "R8", 1'b0);
      for (int i = 1; i < 8; i++) access({tg(i), 4'(i), 4'(15 - i)}, "R8", 1'b0);
      access({tg(8), 4'd0, 4'd0}, "R8", 1'b0);
      access({tg(0), 4'd0, 4'd0}, "R8", 1'b0);
      access({tg(2), 4'd2, 4'd2}, "R8", 1'b0);
      access({tg(1), 4'd1, 4'd1}, "R8", 1'b0);
      access({tg(8), 4'd1, 4'd0}, "R8", 1'b0);

      lcg = 32'h1234_5678;
      for (int k = 0; k < 400; k++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         access({tg(int'(lcg[31:24]) % 12), 2'b00, lcg[9:8], lcg[5:2]}, "R8", lcg[12]);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule